// File: doc/BRIEF.md
# Strided and Indexed Vector Address Generator

This block produces the sequence of word addresses for one vector memory operation aimed at a memory split into several interleaved banks. A command gives a base address, a signed stride, an element count, an addressing mode and a per-bank recovery time. Once the command is accepted, the generator emits element addresses in element order. In unit-stride mode each address is one word past the previous one. In strided mode the step is a signed constant. In indexed mode each address is the base plus the next value taken from an index stream. Indexed mode serves both gathers and scatters.

Each address falls into the bank given by its low address bits. Every bank runs its own recovery countdown after it is accessed. An element whose bank has not yet recovered is held back, and a stall flag reports this. When no conflict holds it back, the generator issues one address per clock. A one-cycle completion pulse comes out together with the final address.

Top module: `vec_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `out_valid`, `stall`, `done` and `idx_ready` are low, and every bank is free.
- R2: In unit-stride mode, element i has address base + i, modulo 2^AW. Elements come out in order, at most one per clock. The first address can appear at the earliest in the second cycle after the cycle in which `start` is sampled.
- R3: In strided mode, element i has address base + i × stride, modulo 2^AW. The stride is a signed SW-bit two's-complement word count, so zero and negative strides are allowed.
- R4: In indexed mode, element i has address base + sign-extended index element i. An index element is consumed only in a cycle where `idx_valid` and `idx_ready` are both high. `idx_ready` is high only while an indexed vector is in progress and the bank of the offered index is free.
- R5: `out_bank` equals the issued address modulo NB, which is the low log2(NB) address bits.
- R6: Two accesses to the same bank are at least `cfg_busy` cycles apart, and a busy value of 0 acts as 1. Recovery countdowns continue across vector boundaries. An element is issued in the first cycle in which its bank is free.
- R7: `stall` is high in exactly those cycles in which an element was ready but held back because its bank was still recovering. Waiting for an index element does not raise `stall`.
- R8: Exactly `cfg_len` addresses are issued per command. `done` pulses together with the last address. A length of 0 gives a `done` pulse in the cycle after `start` and no addresses.
- R9: A `start` seen while a vector is in progress is ignored, and the configuration of the running vector is kept.
- R10: Mode encoding is `cfg_mode`: 2'b00 unit stride, 2'b01 strided, 2'b10 and 2'b11 both indexed. `idx_valid` has no effect outside indexed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new vector command when idle |
| cfg_mode | input | 2 | Addressing mode |
| cfg_base | input | AW | Base word address |
| cfg_stride | input | SW | Signed stride in words |
| cfg_len | input | LW | Element count |
| cfg_busy | input | BTW | Bank recovery time in cycles |
| idx_valid | input | 1 | Index element offered |
| idx_data | input | IW | Signed index element in words |
| idx_ready | output | 1 | Index element taken this cycle if valid |
| out_valid | output | 1 | Address issued |
| out_addr | output | AW | Issued word address |
| out_bank | output | log2(NB) | Bank of the issued address |
| stall | output | 1 | Element held back by a bank conflict |
| done | output | 1 | Last address of the command issued |

## Verification
The bench targets strides that hit one bank on every element, such as a stride equal to the bank count and a stride of zero. A design that timed recovery wrongly would issue such elements too early, or stall one cycle too long. Negative strides and negative indices that wrap below address zero expose a missing sign extension, which would show up as a wrong address. Zero-length and one-element commands, and a `start` during a running vector, catch a completion pulse in the wrong cycle or a vector whose configuration gets overwritten. Gaps in the index stream check that a starved indexed vector neither raises `stall` nor consumes an index while its bank is busy.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [1:0] {
    VAG_UNIT   = 2'b00,
    VAG_STRIDE = 2'b01,
    VAG_INDEX  = 2'b10,
    VAG_INDEX2 = 2'b11
  } vag_mode_e;

  function automatic logic is_index(vag_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/vag_elem_seq.sv
module vag_elem_seq
  import vag_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 8,
  parameter int IW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] stride_i,
  input  logic [LW-1:0] len_i,
  input  vag_mode_e     mode_i,
  input  logic          step_i,
  input  logic [IW-1:0] idx_data_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] inc_o,
  output logic          last_o,
  output logic          index_mode_o
);
  logic [AW-1:0] base_q, inc_q, run_q;
  logic [LW-1:0] cnt_q, len_q;
  logic          idx_q;
  logic [AW-1:0] idx_ext, stride_ext;

  assign stride_ext = {{(AW-SW){stride_i[SW-1]}}, stride_i};
  assign idx_ext    = {{(AW-IW){idx_data_i[IW-1]}}, idx_data_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      inc_q  <= '0;
      run_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      idx_q  <= 1'b0;
    end else if (load_i) begin
      base_q <= base_i;
      run_q  <= base_i;
      cnt_q  <= '0;
      len_q  <= len_i;
      idx_q  <= is_index(mode_i);
      case (mode_i)
        VAG_UNIT:   inc_q <= AW'(1);
        VAG_STRIDE: inc_q <= stride_ext;
        default:    inc_q <= '0;
      endcase
    end else if (step_i) begin
      run_q <= run_q + inc_q;
      cnt_q <= cnt_q + LW'(1);
    end
  end

  assign addr_o       = idx_q ? (base_q + idx_ext) : run_q;
  assign inc_o        = inc_q;
  assign last_o       = (cnt_q == (len_q - LW'(1)));
  assign index_mode_o = idx_q;
endmodule

// File: rtl/vag_bank_timers.sv
module vag_bank_timers #(
  parameter int NB  = 8,
  parameter int BTW = 4,
  localparam int BB = $clog2(NB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [BB-1:0]  sel_i,
  input  logic           load_i,
  input  logic [BTW-1:0] val_i,
  output logic           free_o
);
  logic [NB-1:0] zero;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [BTW-1:0] tmr;
    always_ff @(posedge clk) begin
      if (rst)
        tmr <= '0;
      else if (load_i && (sel_i == BB'(g)))
        tmr <= val_i;
      else if (tmr != '0)
        tmr <= tmr - BTW'(1);
    end
    assign zero[g] = (tmr == '0);
  end

  assign free_o = zero[sel_i];
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int AW  = 16,
  parameter int SW  = 8,
  parameter int IW  = 8,
  parameter int LW  = 8,
  parameter int NB  = 8,
  parameter int BTW = 4,
  localparam int BB = $clog2(NB)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     cfg_mode,
  input  logic [AW-1:0]  cfg_base,
  input  logic [SW-1:0]  cfg_stride,
  input  logic [LW-1:0]  cfg_len,
  input  logic [BTW-1:0] cfg_busy,
  input  logic           idx_valid,
  input  logic [IW-1:0]  idx_data,
  output logic           idx_ready,
  output logic           out_valid,
  output logic [AW-1:0]  out_addr,
  output logic [BB-1:0]  out_bank,
  output logic           stall,
  output logic           done
);
  logic           active_q;
  logic [BTW-1:0] busy_q;
  logic           load, issue, conflict, avail, bank_free;
  logic [AW-1:0]  cand_addr, step_inc;
  logic [BB-1:0]  cand_bank;
  logic           last_elem, index_mode;
  logic [BTW-1:0] recov;

  assign load = start && !active_q && (cfg_len != '0);

  vag_elem_seq #(.AW(AW), .SW(SW), .IW(IW), .LW(LW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load),
    .base_i       (cfg_base),
    .stride_i     (cfg_stride),
    .len_i        (cfg_len),
    .mode_i       (vag_mode_e'(cfg_mode)),
    .step_i       (issue),
    .idx_data_i   (idx_data),
    .addr_o       (cand_addr),
    .inc_o        (step_inc),
    .last_o       (last_elem),
    .index_mode_o (index_mode)
  );

  assign cand_bank = cand_addr[BB-1:0];
  assign recov     = (busy_q == '0) ? '0 : (busy_q - BTW'(1));

  vag_bank_timers #(.NB(NB), .BTW(BTW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (cand_bank),
    .load_i (issue),
    .val_i  (recov),
    .free_o (bank_free)
  );

  assign avail     = active_q && (!index_mode || idx_valid);
  assign issue     = avail && bank_free;
  assign conflict  = avail && !bank_free;
  assign idx_ready = active_q && index_mode && bank_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      busy_q    <= '0;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_bank  <= '0;
      stall     <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (load) begin
        active_q <= 1'b1;
        busy_q   <= cfg_busy;
      end else if (issue && last_elem) begin
        active_q <= 1'b0;
      end
      out_valid <= issue;
      stall     <= conflict;
      done      <= (issue && last_elem) ||
                   (start && !active_q && (cfg_len == '0));
      if (issue) begin
        out_addr <= cand_addr;
        out_bank <= cand_bank;
      end
    end
  end
endmodule

// File: rtl/vec_addr_gen_chk.sv
module vec_addr_gen_chk #(
  parameter int AW  = 16,
  parameter int NB  = 8,
  parameter int BTW = 4,
  localparam int BB = $clog2(NB)
) (
  input logic           clk,
  input logic           rst,
  input logic           active_q,
  input logic           index_mode,
  input logic [AW-1:0]  step_inc,
  input logic [BTW-1:0] busy_q,
  input logic           idx_valid,
  input logic           idx_ready,
  input logic           out_valid,
  input logic [AW-1:0]  out_addr,
  input logic [BB-1:0]  out_bank,
  input logic           stall,
  input logic           done
);
  logic [BTW-1:0] gap [NB];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (rst)
        gap[b] <= '0;
      else if (out_valid && (out_bank == BB'(b)))
        gap[b] <= (busy_q == '0) ? '0 : busy_q - BTW'(1);
      else if (gap[b] != '0)
        gap[b] <= gap[b] - BTW'(1);
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !active_q |=> !out_valid);
  assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !active_q);
  assert_stall_excl_R7: assert property (@(posedge clk) disable iff (rst)
    stall |-> !out_valid);
  assert_idx_taken_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && index_mode) |-> $past(idx_valid && idx_ready));
  assert_stride_step_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !index_mode) |->
      (out_addr == $past(out_addr) + step_inc));
  assert_bank_map_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bank == out_addr[BB-1:0]));
  assert_bank_gap_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gap[out_bank] == '0));
endmodule

bind vec_addr_gen vec_addr_gen_chk #(.AW(AW), .NB(NB), .BTW(BTW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .active_q   (active_q),
  .index_mode (index_mode),
  .step_inc   (step_inc),
  .busy_q     (busy_q),
  .idx_valid  (idx_valid),
  .idx_ready  (idx_ready),
  .out_valid  (out_valid),
  .out_addr   (out_addr),
  .out_bank   (out_bank),
  .stall      (stall),
  .done       (done)
);

// File: tb/vec_addr_gen_test.sv
`timescale 1ns/1ps
module vec_addr_gen_test;
  localparam int AW = 16, SW = 8, IW = 8, LW = 8, NB = 8, BTW = 4;
  localparam int BB = $clog2(NB);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_stride = '0;
  logic [LW-1:0] cfg_len = '0;
  logic [BTW-1:0] cfg_busy = '0;
  logic idx_valid = 1'b0;
  logic [IW-1:0] idx_data = '0;
  logic idx_ready, out_valid, stall, done;
  logic [AW-1:0] out_addr;
  logic [BB-1:0] out_bank;

  vec_addr_gen uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "";
  longint cyc = 0;
  longint free_at [NB];
  bit m_act = 0;
  int m_i, m_len, m_mode, m_busy, m_base, m_stride;
  byte idxv [256];
  bit e_valid, e_stall, e_done, e_ready;
  logic [AW-1:0] e_addr;

  function automatic logic [AW-1:0] elem_addr(int i);
    int a;
    if (m_mode == 0) a = m_base + i;
    else if (m_mode == 1) a = m_base + i * m_stride;
    else a = m_base + int'(idxv[i]);
    return a[AW-1:0];
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] at cycle %0d: got %0h expected %0h", what, tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic [AW-1:0] a;
    int b;
    bit fr;
    e_valid = 0; e_stall = 0; e_done = 0; e_ready = 0;
    if (m_act) begin
      a = elem_addr(m_i);
      b = int'(a[BB-1:0]);
      fr = (cyc >= free_at[b]);
      if (m_mode >= 2) e_ready = fr;
      if ((m_mode < 2) || idx_valid) begin
        if (fr) begin
          e_valid = 1; e_addr = a;
          free_at[b] = cyc + ((m_busy == 0) ? 1 : m_busy);
          m_i++;
          if (m_i == m_len) begin e_done = 1; m_act = 0; end
        end else e_stall = 1;
      end
    end else if (start) begin
      m_mode = int'(cfg_mode); m_base = int'(cfg_base);
      m_stride = int'($signed(cfg_stride)); m_len = int'(cfg_len);
      m_busy = int'(cfg_busy); m_i = 0;
      if (m_len == 0) e_done = 1; else m_act = 1;
    end
    #1;
    check(idx_ready == e_ready, "R4 idx_ready", idx_ready, e_ready);
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check(out_valid == e_valid, "R6 out_valid timing", out_valid, e_valid);
    if (e_valid && out_valid) begin
      check(out_addr == e_addr, "R2 R3 R4 out_addr", out_addr, e_addr);
      check(out_bank == e_addr[BB-1:0], "R5 out_bank", out_bank, e_addr[BB-1:0]);
    end
    check(stall == e_stall, "R7 stall", stall, e_stall);
    check(done == e_done, "R8 done", done, e_done);
  endtask

  task automatic run_vec(int mode, int base, int stride, int len, int busy,
                         int vpct, bit poke);
    int k;
    for (int j = 0; j < 256; j++) idxv[j] = byte'($urandom);
    cfg_mode = 2'(mode); cfg_base = AW'(base); cfg_stride = SW'(stride);
    cfg_len = LW'(len); cfg_busy = BTW'(busy);
    idx_data = idxv[0]; idx_valid = 1'b1;
    start = 1'b1;
    step();
    start = 1'b0;
    k = 0;
    while (m_act && k < 3000) begin
      idx_data = idxv[m_i];
      idx_valid = (($urandom % 100) < vpct);
      if (poke && k == 2) begin
        // R9: a second command mid-vector must be ignored
        start = 1'b1; cfg_base = 16'hBEEF; cfg_stride = 8'd3;
        cfg_len = 8'd2; cfg_mode = 2'b01;
      end else start = 1'b0;
      step();
      k++;
    end
    start = 1'b0; idx_valid = 1'b0;
    if (k >= 3000) check(0, "R8 vector never finished", k, len);
    step();
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) free_at[b] = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(stall == 0, "R1 stall after reset", stall, 0);
    check(done == 0, "R1 done after reset", done, 0);
    check(idx_ready == 0, "R1 idx_ready after reset", idx_ready, 0);
    rst = 1'b0;
    step();

    tag = "R2 unit, busy equals bank count";   run_vec(0, 16'h0100, 0, 16, 8, 50, 0);
    tag = "R2 R6 unit, busy above bank count"; run_vec(0, 16'h0203, 0, 20, 10, 50, 0);
    tag = "R3 R6 stride equal to bank count";  run_vec(1, 16'h0010, 8, 6, 3, 50, 0);
    tag = "R3 negative stride wrap";           run_vec(1, 2, -3, 10, 2, 50, 0);
    tag = "R3 zero stride";                    run_vec(1, 16'h0777, 0, 5, 1, 50, 0);
    tag = "R6 busy zero acts as one";          run_vec(1, 0, 8, 5, 0, 50, 0);
    tag = "R8 zero length";                    run_vec(0, 16'h1234, 0, 0, 4, 50, 0);
    tag = "R8 single element";                 run_vec(1, 16'h0005, 7, 1, 4, 50, 0);
    tag = "R9 start while active";             run_vec(0, 16'h0400, 0, 12, 2, 50, 1);
    tag = "R4 indexed with gaps";              run_vec(2, 16'h0080, 0, 24, 3, 60, 0);
    tag = "R10 indexed alt encoding";          run_vec(3, 16'h0000, 0, 16, 2, 80, 0);
    tag = "R10 idx_valid ignored in stride";   run_vec(1, 16'h0040, 5, 10, 2, 10, 0);

    tag = "random";
    for (int n = 0; n < 60; n++) begin
      run_vec(int'($urandom % 4), int'($urandom % 65536),
              int'($urandom % 17) - 8, int'($urandom % 30),
              int'($urandom % 12), 40 + int'($urandom % 60), ($urandom % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
  end
endmodule